// File: doc/BRIEF.md
# Packet FEC Strip and Error Check

This block takes the serial bits of one selected packet, removes the forward error correction layer in line with the bit stream, and produces a summary of how clean the packet was. The packet has a fixed length. Each codeword is decoded as soon as its last bit arrives.

Three protection modes are supported. In Golay mode, each 24-bit extended Golay codeword becomes 12 corrected data bits. In Hamming mode, each 8-bit extended Hamming codeword becomes 4 data bits. In pass-through mode, every bit is forwarded unchanged. Because parity is dropped, a Golay-protected packet leaves the block at half its received length.

A CRC remainder is computed over every received bit, whatever the mode. When the packet ends, the block raises a one-cycle completion strobe. With it comes a status byte holding the CRC verdict and a saturating count of codewords that could not be corrected. A caller pulses `start`, which latches the mode for that packet. It then feeds the bits with `bit_valid`, at most one per clock, and gathers `out_bit` whenever `out_valid` is high.

Top module: `pkt_fec_strip`

## Requirements
- R1: In Golay mode (mode 2'b10), a 24-bit codeword is taken with its first received bit as the most significant. The first 12 bits are the data and the last 12 are the parity, where the parity equals the data times the symmetric extended Golay matrix. Any pattern of up to 3 bit errors is corrected. For each codeword, the 12 data bits are emitted first-received-first.
- R2: In Golay mode, a codeword with exactly 4 bit errors is counted as uncorrectable. Its first 12 received bits are emitted unchanged.
- R3: In Hamming mode (mode 2'b01), the arrival positions of an 8-bit codeword are numbered 1 to 8. Positions 1, 2 and 4 are check bits, position 8 gives even overall parity, and positions 3, 5, 6 and 7 are the data, emitted in that order. A single bit error is corrected.
- R4: In Hamming mode, a codeword with two bit errors (non-zero syndrome with even overall parity) is counted as uncorrectable. Its data positions are emitted uncorrected.
- R5: Mode 2'b00 and mode 2'b11 both pass data through. Each accepted bit appears on `out_bit`, with `out_valid` high, one clock after it is accepted.
- R6: The CRC register starts at zero for each packet. It shifts in every accepted bit in arrival order, using polynomial `CRC_POLY` (default 16'h1021, non-reflected). Status bit 7 is 1 when the remainder after the last packet bit is non-zero.
- R7: Status bits 6..0 hold the number of uncorrectable codewords in the packet, saturating at 127.
- R8: `done` is high for exactly one clock, in the cycle after the packet's last bit is accepted. `status` takes its new value in that same cycle and holds it until the next `done`.
- R9: `bit_valid` bits are ignored, and produce no output, while no packet is open. The mode is latched at `start`, and changes on `mode` during a packet have no effect.
- R10: After reset, `out_valid`, `out_bit`, `done` and `status` are all zero.
- R11: With `bit_valid` high on every clock, no input bit is lost. A packet yields `PKT_BITS/2` output bits in Golay mode, `PKT_BITS/2` in Hamming mode, and `PKT_BITS` in pass-through mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a packet and latches the mode |
| mode | input | 2 | Protection: 00 none, 01 Hamming, 10 Golay, 11 none |
| bit_valid | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial packet bit |
| out_valid | output | 1 | Qualifies `out_bit` |
| out_bit | output | 1 | Corrected data bit |
| done | output | 1 | One-cycle end-of-packet strobe |
| status | output | 8 | Bit 7 CRC fail, bits 6..0 uncorrectable count |

## Verification
The bench builds the block with `PKT_BITS` set to 1200, which is divisible by both 24 and 8. With that length, a packet of Hamming codewords that all carry double errors holds 150 bad codewords, so the 127 ceiling on the count can be reached. At the default 720 bits it cannot. The CRC width and polynomial keep their defaults, and pass-through packets with the remainder appended exercise the zero-remainder pass case.

// File: rtl/pkt_fec_pkg.sv
package pkt_fec_pkg;

  typedef enum logic [1:0] {
    PM_NONE  = 2'b00,
    PM_HAM   = 2'b01,
    PM_GOLAY = 2'b10,
    PM_RAW   = 2'b11
  } prot_mode_e;

  localparam int STAT_W  = 8;
  localparam int ERRC_W  = STAT_W - 1;
  localparam int GOL_N   = 24;
  localparam int GOL_K   = 12;
  localparam int HAM_N   = 8;
  localparam int HAM_K   = 4;
  localparam logic [10:0] GOLAY_SEED = 11'b11011100010;

  typedef struct packed {
    logic [GOL_K-1:0] data;
    logic             unc;
  } gol_res_t;

  typedef struct packed {
    logic [HAM_K-1:0] data;
    logic             unc;
  } ham_res_t;

  // Row i of the symmetric, self-inverse extended Golay matrix; bit j = column j.
  function automatic logic [11:0] golay_row(input int i);
    logic [11:0] r;
    for (int j = 0; j < 12; j++) begin
      if (i == 11 && j == 11)      r[j] = 1'b0;
      else if (i == 11 || j == 11) r[j] = 1'b1;
      else                         r[j] = GOLAY_SEED[10 - ((i + j) % 11)];
    end
    return r;
  endfunction

  function automatic logic [11:0] golay_mul(input logic [11:0] x);
    logic [11:0] acc;
    acc = '0;
    for (int i = 0; i < 12; i++)
      if (x[i]) acc ^= golay_row(i);
    return acc;
  endfunction

  function automatic gol_res_t golay_decode(input logic [23:0] cw);
    logic [11:0] r1, r2, s, s2, e1;
    logic        found;
    gol_res_t    res;
    r1 = cw[23:12];
    r2 = cw[11:0];
    s  = golay_mul(r1) ^ r2;
    e1 = '0;
    found = 1'b0;
    if ($countones(s) <= 3) found = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (!found && $countones(s ^ golay_row(i)) <= 2) begin
        e1 = 12'(1) << i;
        found = 1'b1;
      end
    end
    s2 = golay_mul(s);
    if (!found && $countones(s2) <= 3) begin
      e1 = s2;
      found = 1'b1;
    end
    for (int i = 0; i < 12; i++) begin
      if (!found && $countones(s2 ^ golay_row(i)) <= 2) begin
        e1 = s2 ^ golay_row(i);
        found = 1'b1;
      end
    end
    res.data = found ? (r1 ^ e1) : r1;
    res.unc  = !found;
    return res;
  endfunction

  // Arrival position p (1..8) lives at cw[8-p].
  function automatic ham_res_t hamming_decode(input logic [7:0] cw);
    logic [2:0] syn;
    logic       par;
    logic [7:0] fx;
    ham_res_t   res;
    syn = '0;
    for (int p = 1; p < 8; p++)
      if (cw[8-p]) syn ^= 3'(p);
    par = ^cw;
    fx  = cw;
    res.unc = 1'b0;
    if (par) begin
      if (syn != 3'd0) fx[8 - int'(syn)] = ~fx[8 - int'(syn)];
    end else if (syn != 3'd0) begin
      res.unc = 1'b1;
    end
    res.data = {fx[5], fx[3], fx[2], fx[1]};
    return res;
  endfunction

endpackage

// File: rtl/pkt_fec_golay_dec.sv
module pkt_fec_golay_dec
  import pkt_fec_pkg::*;
(
  input  logic [GOL_N-1:0] cw,
  output logic [GOL_K-1:0] data,
  output logic             unc
);
  gol_res_t res;
  always_comb begin
    res  = golay_decode(cw);
    data = res.data;
    unc  = res.unc;
  end
endmodule

// File: rtl/pkt_fec_ham_dec.sv
module pkt_fec_ham_dec
  import pkt_fec_pkg::*;
(
  input  logic [HAM_N-1:0] cw,
  output logic [HAM_K-1:0] data,
  output logic             unc
);
  ham_res_t res;
  always_comb begin
    res  = hamming_decode(cw);
    data = res.data;
    unc  = res.unc;
  end
endmodule

// File: rtl/pkt_fec_crc.sv
module pkt_fec_crc #(
  parameter int            W    = 16,
  parameter logic [W-1:0]  POLY = 16'h1021
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_in,
  output logic [W-1:0] crc_nxt
);
  logic [W-1:0] crc_q;

  always_comb begin
    crc_nxt = {crc_q[W-2:0], 1'b0};
    if (crc_q[W-1] ^ bit_in) crc_nxt = crc_nxt ^ POLY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= crc_nxt;
  end
endmodule

// File: rtl/pkt_fec_ser.sv
module pkt_fec_ser #(
  parameter int W = 12,
  localparam int NW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_word,
  input  logic [NW-1:0] load_n,
  input  logic          pass_en,
  input  logic          pass_bit,
  output logic          out_valid,
  output logic          out_bit
);
  logic [W-1:0]  sh;
  logic [NW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      left      <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else begin
      out_valid <= pass_en || (left != '0);
      out_bit   <= pass_en ? pass_bit : ((left != '0) && sh[W-1]);
      if (load) begin
        sh   <= load_word;
        left <= load_n;
      end else if (left != '0) begin
        sh   <= {sh[W-2:0], 1'b0};
        left <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_fec_strip.sv
module pkt_fec_strip
  import pkt_fec_pkg::*;
#(
  parameter int               PKT_BITS = 720,
  parameter int               CRC_W    = 16,
  parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic              bit_valid,
  input  logic              bit_in,
  output logic              out_valid,
  output logic              out_bit,
  output logic              done,
  output logic [STAT_W-1:0] status
);
  localparam int CNT_W = $clog2(PKT_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_BITS - 1);
  localparam logic [ERRC_W-1:0] ERRC_MAX = '1;
  localparam int SNW = $clog2(GOL_K + 1);

  prot_mode_e        mode_q;
  logic              active;
  logic [CNT_W-1:0]  bit_cnt;
  logic [4:0]        cw_pos, cw_last;
  logic [GOL_N-1:0]  cw_shift, shift_nxt;
  logic [ERRC_W-1:0] unc_cnt, cnt_nxt;

  // Named internal events for the checker.
  logic accept, pkt_last, cw_done, cw_unc, pass_mode;

  logic [GOL_K-1:0] g_data;
  logic             g_unc;
  logic [HAM_K-1:0] h_data;
  logic             h_unc;
  logic [CRC_W-1:0] crc_nxt;
  logic [GOL_K-1:0] load_word;
  logic [SNW-1:0]   load_n;

  always_comb begin
    pass_mode = (mode_q == PM_NONE) || (mode_q == PM_RAW);
    unique case (mode_q)
      PM_GOLAY: cw_last = 5'(GOL_N - 1);
      PM_HAM:   cw_last = 5'(HAM_N - 1);
      default:  cw_last = 5'd0;
    endcase
    accept    = active && bit_valid && !start;
    pkt_last  = accept && (bit_cnt == LAST_IDX);
    shift_nxt = {cw_shift[GOL_N-2:0], bit_in};
    cw_done   = accept && !pass_mode && (cw_pos == cw_last);
    cw_unc    = cw_done && ((mode_q == PM_GOLAY) ? g_unc : h_unc);
    cnt_nxt   = unc_cnt + ERRC_W'(cw_unc && (unc_cnt != ERRC_MAX));
    if (mode_q == PM_GOLAY) begin
      load_word = g_data;
      load_n    = SNW'(GOL_K);
    end else begin
      load_word = {h_data, {(GOL_K-HAM_K){1'b0}}};
      load_n    = SNW'(HAM_K);
    end
  end

  pkt_fec_golay_dec u_gol (
    .cw   (shift_nxt),
    .data (g_data),
    .unc  (g_unc)
  );

  pkt_fec_ham_dec u_ham (
    .cw   (shift_nxt[HAM_N-1:0]),
    .data (h_data),
    .unc  (h_unc)
  );

  pkt_fec_crc #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start),
    .en      (accept),
    .bit_in  (bit_in),
    .crc_nxt (crc_nxt)
  );

  pkt_fec_ser #(.W(GOL_K)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cw_done),
    .load_word (load_word),
    .load_n    (load_n),
    .pass_en   (accept && pass_mode),
    .pass_bit  (bit_in),
    .out_valid (out_valid),
    .out_bit   (out_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= PM_NONE;
      active   <= 1'b0;
      bit_cnt  <= '0;
      cw_pos   <= '0;
      cw_shift <= '0;
      unc_cnt  <= '0;
      done     <= 1'b0;
      status   <= '0;
    end else begin
      done <= pkt_last;
      if (start) begin
        active   <= 1'b1;
        mode_q   <= prot_mode_e'(mode);
        bit_cnt  <= '0;
        cw_pos   <= '0;
        cw_shift <= '0;
        unc_cnt  <= '0;
      end else if (accept) begin
        cw_shift <= shift_nxt;
        bit_cnt  <= bit_cnt + 1'b1;
        cw_pos   <= (cw_pos == cw_last) ? 5'd0 : cw_pos + 5'd1;
        unc_cnt  <= cnt_nxt;
        if (pkt_last) begin
          active <= 1'b0;
          status <= {(crc_nxt != '0), cnt_nxt};
        end
      end
    end
  end
endmodule

// File: rtl/pkt_fec_strip_chk.sv
module pkt_fec_strip_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       done,
  input logic [7:0] status,
  input logic       pkt_last,
  input logic       cw_done,
  input logic       cw_unc,
  input logic [6:0] unc_cnt,
  input logic       accept,
  input logic       pass_mode,
  input logic       out_valid
);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_last |=> done);

  a_r8_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_last |=> $stable(status));

  a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_cnt == 7'h7F && !start) |=> unc_cnt == 7'h7F);

  a_r1_good_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_done && !cw_unc && !start) |=> $stable(unc_cnt));

  a_r5_pass_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pass_mode) |=> out_valid);
endmodule

bind pkt_fec_strip pkt_fec_strip_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .done      (done),
  .status    (status),
  .pkt_last  (pkt_last),
  .cw_done   (cw_done),
  .cw_unc    (cw_unc),
  .unc_cnt   (unc_cnt),
  .accept    (accept),
  .pass_mode (pass_mode),
  .out_valid (out_valid)
);

// File: tb/tb_pkt_fec_strip.sv
module tb_pkt_fec_strip;
  localparam int CLK_PERIOD = 10;
  localparam int PKT = 1200;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  nerr;
    logic [3:0]  every;
    logic        gap;
    logic        app;
    logic [15:0] seed;
  } tcase_t;

  localparam int NV = 9;
  localparam tcase_t VECS [NV] = '{
    '{2'd2, 3'd0, 4'd1, 1'b0, 1'b0, 16'h1234},
    '{2'd2, 3'd1, 4'd1, 1'b0, 1'b0, 16'h2345},
    '{2'd2, 3'd3, 4'd2, 1'b0, 1'b0, 16'h3456},
    '{2'd2, 3'd4, 4'd3, 1'b0, 1'b0, 16'h4567},
    '{2'd1, 3'd1, 4'd1, 1'b0, 1'b0, 16'h5678},
    '{2'd1, 3'd2, 4'd4, 1'b0, 1'b0, 16'h6789},
    '{2'd0, 3'd0, 4'd1, 1'b0, 1'b1, 16'h789A},
    '{2'd3, 3'd0, 4'd1, 1'b1, 1'b0, 16'h89AB},
    '{2'd2, 3'd2, 4'd1, 1'b1, 1'b0, 16'h9ABC}
  };
  localparam string TAGS [NV] = '{"R1", "R1", "R1", "R2", "R3", "R4", "R6", "R5", "R11"};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, bit_valid = 1'b0, bit_in = 1'b0;
  logic [1:0] mode = 2'b00;
  logic out_valid, out_bit, done;
  logic [7:0] status;

  pkt_fec_strip #(.PKT_BITS(PKT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .bit_valid(bit_valid), .bit_in(bit_in),
    .out_valid(out_valid), .out_bit(out_bit), .done(done), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit tx [PKT], clean [PKT], expd [PKT], rx [PKT];
  int exp_n, exp_unc, rx_n, done_cnt, done_cyc, last_cyc;
  logic [7:0] done_stat;
  logic [15:0] rng;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (out_valid && rx_n < PKT) begin rx[rx_n] = out_bit; rx_n++; end
    if (done) begin done_cnt++; done_cyc = cyc; done_stat = status; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] x);
    logic [15:0] y;
    y = x ^ (x << 7);
    y = y ^ (y >> 9);
    y = y ^ (y << 8);
    return (y == 16'h0) ? 16'h1 : y;
  endfunction

  // Matrix entry (row, col) of the extended Golay parity matrix.
  function automatic bit gmat(input int r, input int c);
    logic [10:0] pat;
    pat = 11'b11011100010;
    if (r == 11 && c == 11) return 1'b0;
    if (r == 11 || c == 11) return 1'b1;
    return pat[10 - ((r + c) % 11)];
  endfunction

  function automatic logic [15:0] crc_of(input int nbits);
    logic [15:0] r;
    bit fb;
    r = '0;
    for (int k = 0; k < nbits; k++) begin
      fb = r[15] ^ tx[k];
      r = r << 1;
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic build(input logic [1:0] md, input int nerr, input int every,
                       input bit app, input logic [15:0] seed);
    rng = seed;
    exp_n = 0; exp_unc = 0;
    if (md == 2'd2) begin
      for (int c = 0; c < PKT/24; c++) begin
        logic [11:0] m, p;
        bit bad;
        rng = nxt(rng); m = rng[11:0];
        p = '0;
        for (int j = 0; j < 12; j++)
          for (int i = 0; i < 12; i++)
            if (m[i] && gmat(i, j)) p[j] = ~p[j];
        for (int k = 0; k < 24; k++) begin
          clean[c*24+k] = (k < 12) ? m[11-k] : p[23-k];
          tx[c*24+k] = clean[c*24+k];
        end
        bad = 1'b0;
        if (c % every == 0) begin
          for (int j = 0; j < nerr; j++) tx[c*24 + (c*5 + j*7) % 24] ^= 1'b1;
          bad = (nerr >= 4);
        end
        if (bad) exp_unc++;
        for (int k = 0; k < 12; k++) begin
          expd[exp_n] = bad ? tx[c*24+k] : clean[c*24+k];
          exp_n++;
        end
      end
    end else if (md == 2'd1) begin
      for (int c = 0; c < PKT/8; c++) begin
        bit w [9];
        logic [2:0] x;
        bit bad, ov;
        int dp [4];
        dp = '{3, 5, 6, 7};
        rng = nxt(rng);
        for (int p = 1; p <= 8; p++) w[p] = 1'b0;
        for (int q = 0; q < 4; q++) w[dp[q]] = rng[3-q];
        x = '0;
        for (int q = 0; q < 4; q++) if (w[dp[q]]) x ^= 3'(dp[q]);
        w[1] = x[0]; w[2] = x[1]; w[4] = x[2];
        ov = 1'b0;
        for (int p = 1; p <= 7; p++) ov ^= w[p];
        w[8] = ov;
        for (int p = 1; p <= 8; p++) begin clean[c*8+p-1] = w[p]; tx[c*8+p-1] = w[p]; end
        bad = 1'b0;
        if (c % every == 0) begin
          for (int j = 0; j < nerr; j++) tx[c*8 + (c + j*3) % 8] ^= 1'b1;
          bad = (nerr == 2);
        end
        if (bad) exp_unc++;
        for (int q = 0; q < 4; q++) begin
          expd[exp_n] = bad ? tx[c*8+dp[q]-1] : clean[c*8+dp[q]-1];
          exp_n++;
        end
      end
    end else begin
      for (int k = 0; k < PKT; k++) begin rng = nxt(rng); tx[k] = rng[0]; end
      if (app) begin
        logic [15:0] cr;
        cr = crc_of(PKT - 16);
        for (int k = 0; k < 16; k++) tx[PKT-16+k] = cr[15-k];
      end
      for (int k = 0; k < PKT; k++) expd[k] = tx[k];
      exp_n = PKT;
    end
  endtask

  task automatic send(input logic [1:0] md, input bit gap);
    rx_n = 0; done_cnt = 0;
    @(negedge clk); start = 1'b1; mode = md;
    @(negedge clk); start = 1'b0; mode = ~md;
    for (int k = 0; k < PKT; k++) begin
      bit_valid = 1'b1; bit_in = tx[k]; last_cyc = cyc;
      @(negedge clk);
      if (gap && (k % 3 == 2)) begin bit_valid = 1'b0; @(negedge clk); end
    end
    bit_valid = 1'b0;
    repeat (30) @(negedge clk);
  endtask

  task automatic judge(input string req, input bit exp_fail);
    int mism, sat;
    mism = 0;
    for (int k = 0; k < exp_n; k++) if (k < rx_n && rx[k] != expd[k]) mism++;
    sat = (exp_unc > 127) ? 127 : exp_unc;
    check(rx_n == exp_n, (req == "R11") ? "R11" : "R11", "output bit count", rx_n, exp_n);
    check(mism == 0, req, "data mismatches", mism, 0);
    check(done_stat[6:0] == 7'(sat), "R7", "uncorrectable count", done_stat[6:0], sat);
    check(done_stat[7] == exp_fail, "R6", "crc fail bit", done_stat[7], exp_fail);
    check(done_cnt == 1, "R8", "done pulses", done_cnt, 1);
    check(done_cyc == last_cyc + 1, "R8", "done cycle", done_cyc, last_cyc + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rx_n = 0; done_cnt = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(out_valid == 1'b0, "R10", "out_valid in reset", out_valid, 0);
    check(done == 1'b0, "R10", "done in reset", done, 0);
    check(status == 8'h00, "R10", "status in reset", status, 0);
    check(out_bit == 1'b0, "R10", "out_bit in reset", out_bit, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      bit ef;
      build(VECS[v].mode, int'(VECS[v].nerr), int'(VECS[v].every), VECS[v].app, VECS[v].seed);
      ef = (crc_of(PKT) != 16'h0);
      send(VECS[v].mode, VECS[v].gap);
      judge(TAGS[v], ef);
    end

    // R6: pass-through packet with appended remainder must pass
    build(2'd0, 0, 1, 1'b1, 16'hBEEF);
    send(2'd0, 1'b0);
    check(done_stat[7] == 1'b0, "R6", "appended crc passes", done_stat[7], 0);

    // R7: every Hamming codeword double-errored, 150 > 127
    build(2'd1, 2, 1, 1'b0, 16'h0F0F);
    send(2'd1, 1'b0);
    check(done_stat[6:0] == 7'd127, "R7", "saturated count", done_stat[6:0], 127);
    check(exp_unc == 150, "R4", "bench double-error codewords", exp_unc, 150);

    // R9: bits with no open packet are ignored
    begin
      logic [7:0] held;
      held = status;
      rx_n = 0; done_cnt = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk); bit_valid = 1'b1; bit_in = k[0];
      end
      @(negedge clk); bit_valid = 1'b0;
      repeat (20) @(negedge clk);
      check(rx_n == 0, "R9", "outputs while idle", rx_n, 0);
      check(done_cnt == 0, "R9", "done while idle", done_cnt, 0);
      check(status == held, "R9", "status while idle", status, held);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule